// File: doc/BRIEF.md
# Audio Converter Power-Up Sequencer

This controller takes an audio converter from power-on to normal playback. It samples the master clock, the frame clock and the bit clock in its own system-clock domain. It judges whether each clock is active and steps through a fixed bring-up. While the active-low reset pin is held low it sits in a low-power state with the output pull-downs on and the bias node tied to the supply. Once reset is released it waits for a live master clock. It then enables the charge pump and lets it settle for a set number of master-clock cycles.

After settling, the sequencer needs live frame and bit clocks. It counts master-clock rising edges over each frame-clock period. It only moves on when two measurements in a row agree and the value is one of the supported ratios. The power-up stage then switches on the reference, the modulators, the pull-down release and the output amplifiers in that order, with a fixed gap between steps, and finally flags normal operation. If the master clock is lost at any point after power-down, the sequence falls back to power-down.

The encoded state and the locked ratio, with its valid flag, are available as outputs.

Top module: `conv_bringup_seq`

## Requirements
- R1: While `rstN` is low, `seqState` is 0, `pullDownOn` and `biasTieOn` are 1, and `pumpEn`, `refEn`, `modEn`, `ampEn`, `runActive` and `ratioValid` are 0.
- R2: On the first clock edge after `rstN` rises, `seqState` becomes 1 (power-down) and `biasTieOn` drops to 0. The block stays in state 1 with `pumpEn` at 0 for as long as the master clock is not valid.
- R3: Once the master clock is valid, `seqState` becomes 2 (initialization), with `pumpEn` at 1 and `pullDownOn` still at 1. After SETTLE_CYC master-clock rising edges (64 system cycles at the default 32 and a two-cycle master clock, within a few cycles) the state becomes 3 (measure).
- R4: In state 3, the ratio is the number of master-clock rising edges between consecutive frame-clock rising edges. `ratio` is loaded and `ratioValid` is set only when two consecutive measurements are equal and supported. `ratioValid` stays 1 through power-up and normal operation.
- R5: A ratio outside the set {128, 192, 256, 384, 512, 768} keeps the block in state 3 with `ratioValid` at 0 and `refEn` at 0, however long it persists.
- R6: A ratio that differs between consecutive frame periods keeps the block in state 3 with `ratioValid` at 0.
- R7: After the ratio locks, the state becomes 4 (power-up) and `refEn` rises. `modEn` rises STEP_DLY cycles later, `pullDownOn` falls STEP_DLY cycles after that, and `ampEn` rises STEP_DLY cycles after that. `runActive` rises, with state 5 (run), STEP_DLY+1 cycles after `ampEn`. A later enable is never on without the earlier ones.
- R8: With all three clocks valid before reset is released, the time from the reset release to `runActive` is below 50 ms, that is 5,000,000 cycles of a 100 MHz system clock.
- R9: If the master clock stops in states 2 to 5, the block returns to state 1 within 2*WIN_LEN+8 cycles. In state 1, `pullDownOn` is 1 and `pumpEn`, `ampEn`, `runActive` and `ratioValid` are 0.
- R10: A clock counts as valid when at least MIN_EDGES level changes are seen in a WIN_LEN-cycle window. Without a valid bit clock the block does not leave state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the master clock |
| rstN | input | 1 | Active-low reset pin, asynchronous assert |
| mclkIn | input | 1 | Master clock, sampled |
| lrckIn | input | 1 | Frame (left/right) clock, sampled |
| sclkIn | input | 1 | Bit clock, sampled |
| pullDownOn | output | 1 | Output pull-downs engaged |
| biasTieOn | output | 1 | Bias node tied to the analog supply |
| pumpEn | output | 1 | Charge pump enable |
| refEn | output | 1 | Voltage reference enable |
| modEn | output | 1 | Interpolation filter and modulator enable |
| ampEn | output | 1 | Output amplifier enable |
| runActive | output | 1 | Normal operation reached |
| seqState | output | 3 | Encoded state: 0 reset, 1 power-down, 2 init, 3 measure, 4 power-up, 5 run |
| ratio | output | 12 | Locked master-to-frame clock ratio |
| ratioValid | output | 1 | `ratio` holds a locked, supported value |

## Verification
A wrong internal state shows at once on `seqState` and on the decoded enables. For example, a skipped step makes an enable rise on a different cycle than the fixed spacing allows. A corrupted ratio counter shows as a wrong `ratio` at lock, or as the block stalling in state 3. A faulty activity detector shows only after one or two windows of 2048 cycles, as a missed fall-back to state 1 or a stall in states 1 or 3. The bench checks the exact enable spacing and bounds each of these waits.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_PWRDN   = 3'd1,
    ST_INIT    = 3'd2,
    ST_MEASURE = 3'd3,
    ST_POWERUP = 3'd4,
    ST_RUN     = 3'd5
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic settleEn;
    logic measEn;
    logic stepEn;
    logic clrRatio;
  } seqCtl_t;

  localparam int unsigned STEP_LAST = 4;

  function automatic logic ratioSupported(input logic [31:0] r);
    case (r)
      32'd128, 32'd192, 32'd256, 32'd384, 32'd512, 32'd768: ratioSupported = 1'b1;
      default: ratioSupported = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import conv_seq_pkg::*;
#(
  parameter int WIN_LEN    = 2048,
  parameter int MIN_EDGES  = 2,
  parameter int SETTLE_CYC = 32,
  parameter int STEP_DLY   = 16,
  parameter int RATIO_W    = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mclkIn,
  input  logic               lrckIn,
  input  logic               sclkIn,
  input  seqCtl_t            ctl,
  output logic               mclkOk,
  output logic               lrckOk,
  output logic               sclkOk,
  output logic               settleDone,
  output logic [2:0]         stepNum,
  output logic [RATIO_W-1:0] ratio,
  output logic               ratioValid
);

  localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int EDGE_W = $clog2(WIN_LEN + 1);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int DLY_W  = $clog2(STEP_DLY + 1);
  localparam logic [EDGE_W-1:0]  MIN_E    = EDGE_W'(MIN_EDGES);
  localparam logic [WIN_W-1:0]   WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [SET_W-1:0]   SET_END  = SET_W'(SETTLE_CYC);
  localparam logic [DLY_W-1:0]   DLY_LAST = DLY_W'(STEP_DLY - 1);
  localparam logic [RATIO_W-1:0] CNT_MAX  = {RATIO_W{1'b1}};

  logic [2:0] rawV;
  logic [2:0] okV;
  logic       mclkRise, lrckRise;
  logic [WIN_W-1:0] winCnt;
  logic       winEnd;

  assign rawV   = {sclkIn, lrckIn, mclkIn};
  assign winEnd = (winCnt == WIN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       winCnt <= '0;
    else if (winEnd) winCnt <= '0;
    else             winCnt <= winCnt + 1'b1;
  end

  // one synchronizer + activity counter per sampled clock
  for (genvar k = 0; k < 3; k++) begin : g_act
    logic s1, s2, s3, okR, tog;
    logic [EDGE_W-1:0] eCnt;
    assign tog = s2 ^ s3;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        {s3, s2, s1} <= 3'b000;
        eCnt <= '0;
        okR  <= 1'b0;
      end else begin
        {s3, s2, s1} <= {s2, s1, rawV[k]};
        if (winEnd) begin
          okR  <= (eCnt + EDGE_W'(tog)) >= MIN_E;
          eCnt <= '0;
        end else if (tog) begin
          eCnt <= eCnt + 1'b1;
        end
      end
    end
    assign okV[k] = okR;
    if (k == 0) begin : g_m
      assign mclkRise = s2 & ~s3;
    end else if (k == 1) begin : g_l
      assign lrckRise = s2 & ~s3;
    end
  end

  assign mclkOk = okV[0];
  assign lrckOk = okV[1];
  assign sclkOk = okV[2];

  // charge-pump settle counter, in master-clock edges
  logic [SET_W-1:0] setCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              setCnt <= '0;
    else if (!ctl.settleEn)                 setCnt <= '0;
    else if (mclkRise && setCnt != SET_END) setCnt <= setCnt + 1'b1;
  end
  assign settleDone = (setCnt == SET_END);

  // power-up step timer
  logic [DLY_W-1:0] stepTmr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepTmr <= '0;
      stepNum <= '0;
    end else if (!ctl.stepEn) begin
      stepTmr <= '0;
      stepNum <= '0;
    end else if (stepNum != 3'(STEP_LAST)) begin
      if (stepTmr == DLY_LAST) begin
        stepTmr <= '0;
        stepNum <= stepNum + 1'b1;
      end else begin
        stepTmr <= stepTmr + 1'b1;
      end
    end
  end

  // ratio counter: master rises between frame rises, lock on two equal
  logic [RATIO_W-1:0] mCnt, prevCnt;
  logic armed, havePrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= '0; prevCnt <= '0; armed <= 1'b0; havePrev <= 1'b0;
      ratio <= '0; ratioValid <= 1'b0;
    end else begin
      if (ctl.clrRatio) ratioValid <= 1'b0;
      if (!ctl.measEn) begin
        mCnt <= '0; armed <= 1'b0; havePrev <= 1'b0;
      end else if (lrckRise) begin
        if (armed) begin
          prevCnt  <= mCnt;
          havePrev <= 1'b1;
          if (havePrev && mCnt == prevCnt && ratioSupported(32'(mCnt))) begin
            ratio      <= mCnt;
            ratioValid <= 1'b1;
          end
        end
        armed <= 1'b1;
        mCnt  <= RATIO_W'(mclkRise);
      end else if (mclkRise && mCnt != CNT_MAX) begin
        mCnt <= mCnt + 1'b1;
      end
    end
  end

  // R4
  valid_ratio_supported_chk: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid |-> ratioSupported(32'(ratio)));
  // R7
  step_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepNum <= 3'(STEP_LAST));
  // R4
  lock_only_measuring_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioValid) |-> $past(ctl.measEn));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mclkOk,
  input  logic       lrckOk,
  input  logic       sclkOk,
  input  logic       settleDone,
  input  logic [2:0] stepNum,
  input  logic       ratioValid,
  output seqCtl_t    ctl,
  output logic       pullDownOn,
  output logic       biasTieOn,
  output logic       pumpEn,
  output logic       refEn,
  output logic       modEn,
  output logic       ampEn,
  output logic       runActive,
  output logic [2:0] seqState
);

  seqState_e state, nextState;
  logic      active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  assign active = (state == ST_INIT) || (state == ST_MEASURE) ||
                  (state == ST_POWERUP) || (state == ST_RUN);

  always_comb begin
    nextState = state;
    if (active && !mclkOk) begin
      nextState = ST_PWRDN;
    end else begin
      case (state)
        ST_RESET:   nextState = ST_PWRDN;
        ST_PWRDN:   if (mclkOk) nextState = ST_INIT;
        ST_INIT:    if (settleDone) nextState = ST_MEASURE;
        ST_MEASURE: if (ratioValid) nextState = ST_POWERUP;
        ST_POWERUP: if (stepNum == 3'(STEP_LAST)) nextState = ST_RUN;
        default:    nextState = state;
      endcase
    end
  end

  assign ctl.settleEn = (state == ST_INIT);
  assign ctl.measEn   = (state == ST_MEASURE) && lrckOk && sclkOk;
  assign ctl.stepEn   = (state == ST_POWERUP);
  assign ctl.clrRatio = (state == ST_PWRDN);

  assign biasTieOn  = (state == ST_RESET);
  assign pumpEn     = active;
  assign runActive  = (state == ST_RUN);
  assign refEn      = (state == ST_POWERUP) || runActive;
  assign modEn      = ((state == ST_POWERUP) && stepNum >= 3'd1) || runActive;
  assign pullDownOn = !(((state == ST_POWERUP) && stepNum >= 3'd2) || runActive);
  assign ampEn      = ((state == ST_POWERUP) && stepNum >= 3'd3) || runActive;
  assign seqState   = state;

  // R7
  mod_after_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    modEn |-> refEn);
  // R7
  release_after_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pullDownOn |-> modEn);
  // R7
  amp_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ampEn |-> !pullDownOn);
  // R4
  run_needs_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    runActive |-> ratioValid);
  // R9
  mclk_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !mclkOk) |=> (state == ST_PWRDN));
  // R2
  leave_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET) |=> (state == ST_PWRDN));

endmodule

// File: rtl/conv_bringup_seq.sv
module conv_bringup_seq
  import conv_seq_pkg::*;
#(
  parameter int WIN_LEN    = 2048,
  parameter int MIN_EDGES  = 2,
  parameter int SETTLE_CYC = 32,
  parameter int STEP_DLY   = 16,
  parameter int RATIO_W    = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mclkIn,
  input  logic               lrckIn,
  input  logic               sclkIn,
  output logic               pullDownOn,
  output logic               biasTieOn,
  output logic               pumpEn,
  output logic               refEn,
  output logic               modEn,
  output logic               ampEn,
  output logic               runActive,
  output logic [2:0]         seqState,
  output logic [RATIO_W-1:0] ratio,
  output logic               ratioValid
);

  seqCtl_t    ctl;
  logic       mclkOk, lrckOk, sclkOk, settleDone;
  logic [2:0] stepNum;

  seq_datapath #(
    .WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES), .SETTLE_CYC(SETTLE_CYC),
    .STEP_DLY(STEP_DLY), .RATIO_W(RATIO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mclkIn(mclkIn), .lrckIn(lrckIn), .sclkIn(sclkIn),
    .ctl(ctl), .mclkOk(mclkOk), .lrckOk(lrckOk), .sclkOk(sclkOk),
    .settleDone(settleDone), .stepNum(stepNum), .ratio(ratio),
    .ratioValid(ratioValid)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mclkOk(mclkOk), .lrckOk(lrckOk), .sclkOk(sclkOk),
    .settleDone(settleDone), .stepNum(stepNum), .ratioValid(ratioValid),
    .ctl(ctl), .pullDownOn(pullDownOn), .biasTieOn(biasTieOn), .pumpEn(pumpEn),
    .refEn(refEn), .modEn(modEn), .ampEn(ampEn), .runActive(runActive),
    .seqState(seqState)
  );

endmodule

// File: tb/conv_bringup_seq_tb.sv
module conv_bringup_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_DLY   = 16;
  localparam int WIN_LEN    = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mclk = 1'b0, lrck = 1'b0, sclk = 1'b0;
  logic pullDownOn, biasTieOn, pumpEn, refEn, modEn, ampEn, runActive, ratioValid;
  logic [2:0]  seqState;
  logic [11:0] ratio;

  int  checks = 0, fails = 0, cyc = 0;
  bit  mclkRun = 1, sclkRun = 1, altMode = 0;
  int  reqRatio = 256, altRatio = 192, curRatio = 256, phase = 0, sDiv = 0;

  conv_bringup_seq u_dut (
    .clk(clk), .rstN(rstN), .mclkIn(mclk), .lrckIn(lrck), .sclkIn(sclk),
    .pullDownOn(pullDownOn), .biasTieOn(biasTieOn), .pumpEn(pumpEn),
    .refEn(refEn), .modEn(modEn), .ampEn(ampEn), .runActive(runActive),
    .seqState(seqState), .ratio(ratio), .ratioValid(ratioValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // clock generator: master toggles every cycle, frame toggles on master falls
  always @(negedge clk) begin
    if (sclkRun) begin
      if (sDiv == 2) begin sDiv <= 0; sclk <= ~sclk; end
      else sDiv <= sDiv + 1;
    end
    if (mclkRun) begin
      mclk <= ~mclk;
      if (mclk) begin
        if (phase + 1 >= curRatio / 2) begin
          phase <= 0;
          lrck  <= ~lrck;
          if (!lrck) curRatio <= (altMode && curRatio == reqRatio) ? altRatio : reqRatio;
        end else begin
          phase <= phase + 1;
        end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 195000) begin
    checks++; fails++;
    $display("FAIL watchdog: actual cycle %0d expected below 195000", cyc);
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitState(input int code, input int limit, input string req);
    int n = 0;
    while (seqState != 3'(code) && n < limit) begin @(negedge clk); n++; end
    chk(seqState == 3'(code), req, int'(seqState), code);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; idle(8);
  endtask

  task automatic release_rst();
    @(negedge clk); rstN = 1'b1; @(negedge clk);
  endtask

  // R1
  task automatic t_resetState();
    doReset();
    chk(seqState == 3'd0, "R1 state", int'(seqState), 0);
    chk(pullDownOn && biasTieOn, "R1 pulldown/bias", {pullDownOn, biasTieOn}, 3);
    chk(!pumpEn && !refEn && !modEn && !ampEn && !runActive && !ratioValid,
        "R1 enables off", {pumpEn, refEn, modEn, ampEn, runActive, ratioValid}, 0);
  endtask

  // full bring-up from release with clocks already running (R2 R3 R4 R7 R8)
  task automatic bringUp(input int r);
    int t0, tI, tRef, tMod, tRel, tAmp, tRun, n;
    reqRatio = r; altMode = 0;
    doReset();
    idle(2 * r + 8);
    t0 = cyc;
    release_rst();
    chk(seqState == 3'd1 && !biasTieOn, "R2 power-down after release", int'(seqState), 1);
    waitState(2, 3 * WIN_LEN, "R3 reach init");
    chk(pumpEn && pullDownOn, "R3 pump on, pulldowns on", {pumpEn, pullDownOn}, 3);
    tI = cyc;
    waitState(3, 200, "R3 reach measure");
    chk((cyc - tI) >= 60 && (cyc - tI) <= 70, "R3 settle time", cyc - tI, 64);
    waitState(4, 8 * r + 100, "R4 lock leads to power-up");
    chk(ratioValid && ratio == 12'(r), "R4 ratio", int'(ratio), r);
    tRef = cyc; tMod = -1; tRel = -1; tAmp = -1; tRun = -1; n = 0;
    chk(refEn && !modEn, "R7 reference first", {refEn, modEn}, 2);
    while (tRun < 0 && n < 200) begin
      @(negedge clk); n++;
      if (modEn && tMod < 0) tMod = cyc;
      if (!pullDownOn && tRel < 0) tRel = cyc;
      if (ampEn && tAmp < 0) tAmp = cyc;
      if (runActive && tRun < 0) tRun = cyc;
    end
    chk(tMod - tRef == STEP_DLY, "R7 ref to mod", tMod - tRef, STEP_DLY);
    chk(tRel - tMod == STEP_DLY, "R7 mod to release", tRel - tMod, STEP_DLY);
    chk(tAmp - tRel == STEP_DLY, "R7 release to amp", tAmp - tRel, STEP_DLY);
    chk(tRun - tAmp == STEP_DLY + 1, "R7 amp to run", tRun - tAmp, STEP_DLY + 1);
    chk(seqState == 3'd5 && ratioValid, "R7 run state", int'(seqState), 5);
    chk(tRun - t0 < 5000000, "R8 bring-up time", tRun - t0, 5000000);
  endtask

  // R2 no master clock
  task automatic t_noMclk();
    doReset(); mclkRun = 0; reqRatio = 256;
    release_rst(); idle(5000);
    chk(seqState == 3'd1 && !pumpEn, "R2 wait for master clock", int'(seqState), 1);
    mclkRun = 1;
    waitState(2, 3 * WIN_LEN, "R2 init after master clock");
    waitState(5, 8000, "R2 run after master clock");
  endtask

  // R9
  task automatic t_loss();
    chk(seqState == 3'd5, "R9 precondition run", int'(seqState), 5);
    mclkRun = 0;
    waitState(1, 2 * WIN_LEN + 8, "R9 fall back to power-down");
    chk(pullDownOn && !pumpEn && !ampEn && !runActive, "R9 outputs safe",
        {pullDownOn, pumpEn, ampEn, runActive}, 8);
    idle(2);
    chk(!ratioValid, "R9 ratio cleared", ratioValid, 0);
    mclkRun = 1;
    waitState(5, 3 * WIN_LEN + 3000, "R9 recovers");
  endtask

  // R5
  task automatic t_unsupported();
    doReset(); reqRatio = 100;
    release_rst();
    waitState(3, 3 * WIN_LEN + 200, "R5 reach measure");
    idle(5000);
    chk(seqState == 3'd3 && !ratioValid && !refEn, "R5 unsupported held",
        {seqState, ratioValid, refEn}, 12);
    reqRatio = 384;
    waitState(5, 6000, "R5 lock after fix");
    chk(ratio == 12'd384, "R5 ratio after fix", int'(ratio), 384);
  endtask

  // R6
  task automatic t_alternate();
    doReset(); reqRatio = 128; altRatio = 192; altMode = 1;
    release_rst();
    waitState(3, 3 * WIN_LEN + 200, "R6 reach measure");
    idle(5000);
    chk(seqState == 3'd3 && !ratioValid, "R6 changing ratio held",
        {seqState, ratioValid}, 6);
    altMode = 0;
    waitState(5, 4000, "R6 lock after steady");
    chk(ratio == 12'd128, "R6 ratio after steady", int'(ratio), 128);
  endtask

  // R10
  task automatic t_noSclk();
    doReset(); sclkRun = 0; reqRatio = 512;
    release_rst();
    waitState(3, 3 * WIN_LEN + 200, "R10 reach measure");
    idle(5000);
    chk(seqState == 3'd3 && !ratioValid, "R10 no bit clock held",
        {seqState, ratioValid}, 6);
    sclkRun = 1;
    waitState(5, 3 * WIN_LEN + 5000, "R10 run with bit clock");
    chk(ratio == 12'd512, "R10 ratio", int'(ratio), 512);
  endtask

  initial begin
    t_resetState();
    bringUp(256);
    bringUp(768);
    bringUp(128);
    t_noMclk();
    t_loss();
    t_unsupported();
    t_alternate();
    t_noSclk();
    finish_run();
  end

endmodule